// File: doc/BRIEF.md
# Clock Generator Divider Bank with Staged Commit

This block holds the three divider settings of a clock generator: the reference (input) divider, the loop (feedback) divider and the post (output) divider. Software reaches them through a plain 32-bit register write/read port. Every written word carries its own hold flag. A write with the flag set only fills a staging copy. A write with the flag clear moves all three staged words into the active set at the same clock edge. The usual sequence stages the input and feedback words and then commits with the output word. The three active words leave the block on their own ports and feed the clock generator.

A commit starts a modelled relock. The lock flag drops at the commit edge. It rises again after `RELOCK_CYCLES` reference cycles, which stands in for the analog settling time. If any committed word decodes to a ratio of zero, the block reports an error and the lock flag stays low until a valid commit arrives. Software that polls the separate status word after its relock budget then sees a timeout.

The control is a three-state machine. LOCKED is the reset state and holds the lock flag high. RELOCK counts settling cycles. FAULT holds the error flag. The transitions are: LOCKED→RELOCK on a valid commit, LOCKED→FAULT on an invalid commit, RELOCK→LOCKED when the count ends, RELOCK→RELOCK on a valid commit (the count restarts), RELOCK→FAULT on an invalid commit, FAULT→RELOCK on a valid commit, and FAULT→FAULT on an invalid commit.

Top module: `pll_div_bank`

## Requirements
- R1: While reset is asserted, and after it is released, all three active words read 0x2000 (bypass set, ratio 1), the lock flag is 1, the error flag is 0 and the status word reads 0x1.
- R2: The divider is selected by address bits [3:2]. Value 0 selects the input divider, 1 the feedback divider and 2 the output divider. Bits [1:0] are ignored. A read returns the active word with every bit from 14 upward at zero. Address bits [3:2] = 3 read as 0, and writes to them change neither the active words nor the status.
- R3: Word fields: low count in [5:0], high count in [11:6], edge in [12], bypass in [13], hold flag in [14]. A divider write with bit 14 set changes only the staging copy. The active words and the status are unchanged afterwards.
- R4: A divider write with bit 14 clear copies all three staging copies, including the word written in that cycle, into the active words at that one clock edge.
- R5: After a valid commit edge, the lock flag reads 0 from that edge on and reads 1 from `RELOCK_CYCLES` edges after it. A further valid commit during relock restarts the count.
- R6: A word's ratio is 1 when bypass is set, else high count plus low count. A commit in which any ratio is 0 sets the error flag at the commit edge. The lock flag then stays 0 however long no new commit arrives.
- R7: A valid commit clears the error flag at its commit edge, and relock proceeds as in R5.
- R8: The status word has the lock flag in bit 0, the error flag in bit 1 and zero in all other bits. The two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the register port |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Active word of the addressed divider (combinational) |
| stat_rdata | output | DATA_W | Status word: lock in bit 0, error in bit 1 |
| in_div_word | output | WORD_W | Active input divider word |
| fb_div_word | output | WORD_W | Active feedback divider word |
| out_div_word | output | WORD_W | Active output divider word |
| pll_locked | output | 1 | Lock flag |
| pll_error | output | 1 | Invalid-setting flag |

## Verification
A staging register that leaks into the active set shows on the divider word ports one edge after a hold-flag write, before any commit has happened. A state machine left in the wrong state shows as a lock flag that rises early or late against a count started at the commit edge. It can also show as a lock flag that rises while the error flag is still set, or that rises after an invalid commit. Each of these is visible within `RELOCK_CYCLES` plus one cycle of the write that should have caused it. A decoding slip in the ratio check shows at the first commit of a bypass word with zero counts, or of a zero word without bypass.

// File: rtl/pll_bank_pkg.sv
`timescale 1ns/1ps
package pll_bank_pkg;

    // divider word layout
    localparam int FLD_W     = 6;
    localparam int LOW_LSB   = 0;
    localparam int HIGH_LSB  = 6;
    localparam int EDGE_BIT  = 12;
    localparam int BYP_BIT   = 13;
    localparam int NOUPD_BIT = 14;
    localparam int WORD_W    = 14;
    localparam int NUM_DIV   = 3;
    localparam int RATIO_W   = FLD_W + 1;

    localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << BYP_BIT;

    typedef enum logic [1:0] {
        RL_LOCKED = 2'd0,
        RL_RELOCK = 2'd1,
        RL_FAULT  = 2'd2
    } relock_state_e;

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [WORD_W-1:0] w);
        logic [RATIO_W-1:0] r;
        if (w[BYP_BIT]) begin
            r = RATIO_W'(1);
        end else begin
            r = {1'b0, w[HIGH_LSB +: FLD_W]} + {1'b0, w[LOW_LSB +: FLD_W]};
        end
        return r;
    endfunction

endpackage

// File: rtl/pll_div_slot.sv
`timescale 1ns/1ps
module pll_div_slot
    import pll_bank_pkg::*;
#(
    parameter int                 W        = WORD_W,
    parameter logic [W-1:0]       RST_WORD = RESET_WORD[W-1:0]
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_word,
    input  logic         commit,
    output logic [W-1:0] staged_o,
    output logic [W-1:0] active_o
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    always_comb begin
        staged_o = wr_hit ? wr_word : shadow_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= RST_WORD;
            active_q <= RST_WORD;
        end else begin
            shadow_q <= staged_o;
            if (commit) begin
                active_q <= staged_o;
            end
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/pll_relock_fsm.sv
`timescale 1ns/1ps
module pll_relock_fsm
    import pll_bank_pkg::*;
#(
    parameter int RELOCK_CYCLES = 25000,
    parameter int CNT_W         = $clog2(RELOCK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic cfg_ok,
    output logic locked_o,
    output logic error_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RELOCK_CYCLES - 1);

    relock_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RL_LOCKED: begin
                if (commit) begin
                    st_d  = cfg_ok ? RL_RELOCK : RL_FAULT;
                    cnt_d = '0;
                end
            end
            RL_RELOCK: begin
                if (commit) begin
                    st_d  = cfg_ok ? RL_RELOCK : RL_FAULT;
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d = RL_LOCKED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RL_FAULT: begin
                if (commit) begin
                    st_d  = cfg_ok ? RL_RELOCK : RL_FAULT;
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = RL_LOCKED;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RL_LOCKED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        locked_o = 1'b0;
        error_o  = 1'b0;
        unique case (st_q)
            RL_LOCKED: locked_o = 1'b1;
            RL_RELOCK: locked_o = 1'b0;
            RL_FAULT:  error_o  = 1'b1;
            default:   locked_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pll_div_bank.sv
`timescale 1ns/1ps
module pll_div_bank
    import pll_bank_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 4,
    parameter int DIV_W         = WORD_W,
    parameter int RELOCK_CYCLES = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] stat_rdata,
    output logic [DIV_W-1:0]  in_div_word,
    output logic [DIV_W-1:0]  fb_div_word,
    output logic [DIV_W-1:0]  out_div_word,
    output logic              pll_locked,
    output logic              pll_error
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int CNT_W = $clog2(RELOCK_CYCLES + 1);

    logic [IDX_W-1:0] sel_idx;
    logic             div_hit;
    logic             commit;
    logic             cfg_ok;
    logic [DIV_W-1:0] staged [NUM_DIV];
    logic [DIV_W-1:0] active [NUM_DIV];

    assign sel_idx = reg_addr[ADDR_W-1:2];
    assign div_hit = (sel_idx < IDX_W'(NUM_DIV));
    assign commit  = reg_wr && div_hit && !reg_wdata[NOUPD_BIT];

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_slot
        pll_div_slot #(
            .W        (DIV_W),
            .RST_WORD (RESET_WORD[DIV_W-1:0])
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (reg_wr && (sel_idx == IDX_W'(g))),
            .wr_word  (reg_wdata[DIV_W-1:0]),
            .commit   (commit),
            .staged_o (staged[g]),
            .active_o (active[g])
        );
    end

    always_comb begin
        cfg_ok = 1'b1;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (ratio_of(staged[i]) == '0) begin
                cfg_ok = 1'b0;
            end
        end
    end

    pll_relock_fsm #(
        .RELOCK_CYCLES (RELOCK_CYCLES),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .cfg_ok   (cfg_ok),
        .locked_o (pll_locked),
        .error_o  (pll_error)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                reg_rdata[DIV_W-1:0] = active[i];
            end
        end
    end

    always_comb begin
        stat_rdata    = '0;
        stat_rdata[0] = pll_locked;
        stat_rdata[1] = pll_error;
    end

    assign in_div_word  = active[0];
    assign fb_div_word  = active[1];
    assign out_div_word = active[2];

endmodule

// File: rtl/pll_div_bank_chk.sv
`timescale 1ns/1ps
module pll_div_bank_chk
    import pll_bank_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 4,
    parameter int DIV_W         = WORD_W,
    parameter int RELOCK_CYCLES = 25000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DIV_W-1:0]  in_div_word,
    input logic [DIV_W-1:0]  fb_div_word,
    input logic [DIV_W-1:0]  out_div_word,
    input logic              pll_locked,
    input logic              pll_error
);

    logic        div_wr;
    logic        cmt;
    logic        hold_wr;
    logic [31:0] since_cmt;

    assign div_wr  = reg_wr && (reg_addr[ADDR_W-1:2] < (ADDR_W-2)'(NUM_DIV));
    assign cmt     = div_wr && !reg_wdata[NOUPD_BIT];
    assign hold_wr = div_wr && reg_wdata[NOUPD_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmt <= '0;
        end else if (cmt) begin
            since_cmt <= '0;
        end else if (since_cmt != 32'hFFFF_FFFF) begin
            since_cmt <= since_cmt + 1;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:DIV_W] == '0); // R2

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> ($stable(in_div_word) && $stable(fb_div_word) && $stable(out_div_word))); // R3

    AST_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt |=> ($stable(in_div_word) && $stable(fb_div_word) && $stable(out_div_word))); // R4

    AST_COMMIT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmt |=> !pll_locked); // R5

    AST_RELOCK_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_locked) |-> (since_cmt == 32'(RELOCK_CYCLES))); // R5

    AST_ERR_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_error) |-> $past(cmt)); // R6

    AST_ERR_CLEAR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_error) |-> $past(cmt)); // R7

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_locked && pll_error)); // R8

endmodule

bind pll_div_bank pll_div_bank_chk #(
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .DIV_W         (DIV_W),
    .RELOCK_CYCLES (RELOCK_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .in_div_word  (in_div_word),
    .fb_div_word  (fb_div_word),
    .out_div_word (out_div_word),
    .pll_locked   (pll_locked),
    .pll_error    (pll_error)
);

// File: tb/pll_div_bank_tb.sv
`timescale 1ns/1ps
module pll_div_bank_tb_top;

    localparam int RLK = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] stat_rdata;
    logic [13:0] in_div_word;
    logic [13:0] fb_div_word;
    logic [13:0] out_div_word;
    logic        pll_locked;
    logic        pll_error;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    pll_div_bank #(
        .RELOCK_CYCLES (RLK)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .stat_rdata   (stat_rdata),
        .in_div_word  (in_div_word),
        .fb_div_word  (fb_div_word),
        .out_div_word (out_div_word),
        .pll_locked   (pll_locked),
        .pll_error    (pll_error)
    );

    // selectors: 0 rdata, 1 status, 2 in, 3 fb, 4 out, 5 lock, 6 error
    function automatic logic [31:0] pick(input int sel);
        case (sel)
            0: return reg_rdata;
            1: return stat_rdata;
            2: return {18'd0, in_div_word};
            3: return {18'd0, fb_div_word};
            4: return {18'd0, out_div_word};
            5: return {31'd0, pll_locked};
            default: return {31'd0, pll_error};
        endcase
    endfunction

    // word encoding for a wanted ratio
    function automatic logic [31:0] enc(input int r);
        logic [31:0] w;
        w = '0;
        w[5:0]  = 6'((r + 1) / 2);
        w[11:6] = 6'(r / 2);
        w[12]   = (r % 2) == 1;
        w[13]   = (r == 1);
        return w;
    endfunction

    function automatic void expect_item(input int sel, input logic [31:0] v, input string r);
        exp_item_t it;
        it.sel = sel;
        it.exp = v;
        it.req = r;
        sb_q.push_back(it);
    endfunction

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = pick(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] v, input string r);
        @(negedge clk);
        reg_addr = a;
        expect_item(0, v, r);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [31:0] HOLD = 32'h0000_4000;

    initial begin
        // R1 during reset
        idle(2);
        expect_item(2, 32'h2000, "R1");
        expect_item(5, 32'h1, "R1");
        idle(1);
        rst_n = 1'b1;
        idle(1);
        expect_item(2, 32'h2000, "R1");
        expect_item(3, 32'h2000, "R1");
        expect_item(4, 32'h2000, "R1");
        expect_item(5, 32'h1, "R1");
        expect_item(6, 32'h0, "R1");
        expect_item(1, 32'h1, "R1_R8");
        rd(4'h0, 32'h2000, "R2");
        rd(4'hC, 32'h0, "R2");

        // staged writes with hold flag
        wr(4'h0, HOLD | enc(2));
        expect_item(2, 32'h2000, "R3");
        expect_item(1, 32'h1, "R3");
        wr(4'h5, HOLD | enc(45));
        expect_item(3, 32'h2000, "R3");
        expect_item(2, 32'h2000, "R3");

        // commit through output divider
        wr(4'h8, enc(10));
        expect_item(2, enc(2), "R4");
        expect_item(3, enc(45), "R4");
        expect_item(4, enc(10), "R4");
        expect_item(5, 32'h0, "R5");
        expect_item(6, 32'h0, "R5");
        idle(RLK - 1);
        expect_item(5, 32'h0, "R5");
        idle(1);
        expect_item(5, 32'h1, "R5");
        rd(4'h4, enc(45), "R2");
        rd(4'hB, enc(10), "R2");

        // reserved bits dropped, commit from feedback address
        wr(4'h4, 32'hFFFF_8000 | enc(54));
        expect_item(3, enc(54), "R2_R4");
        expect_item(5, 32'h0, "R5");
        rd(4'h4, enc(54), "R2");
        idle(9);
        // restart during relock, commit from input address
        wr(4'h0, enc(1));
        expect_item(2, 32'h3001, "R4");
        idle(RLK - 1);
        expect_item(5, 32'h0, "R5_restart");
        idle(1);
        expect_item(5, 32'h1, "R5_restart");

        // invalid setting: zero ratio without bypass
        wr(4'h4, HOLD);
        expect_item(5, 32'h1, "R3");
        expect_item(3, enc(54), "R3");
        wr(4'h8, enc(10));
        expect_item(6, 32'h1, "R6");
        expect_item(5, 32'h0, "R6");
        expect_item(1, 32'h2, "R6_R8");
        idle(2 * RLK);
        expect_item(5, 32'h0, "R6_timeout");
        expect_item(6, 32'h1, "R6_timeout");
        rd(4'h4, 32'h0, "R6");

        // bypass with zero counts is valid and clears the error
        wr(4'h4, 32'h2000);
        expect_item(6, 32'h0, "R7");
        expect_item(5, 32'h0, "R7");
        idle(RLK);
        expect_item(5, 32'h1, "R7");
        expect_item(1, 32'h1, "R7_R8");

        // unmapped offset: write ignored
        wr(4'hC, 32'h0);
        expect_item(5, 32'h1, "R2");
        expect_item(2, 32'h3001, "R2");
        expect_item(3, 32'h2000, "R2");
        expect_item(4, enc(10), "R2");
        idle(2);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, all requirements, actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule